// File: doc/BRIEF.md
# Two-Wire JTAG Slot Sequencer

This block is the master end of a serial debug link that carries JTAG over two wires: a link clock that it always drives, and one shared data line that it drives or releases. Each JTAG clock cycle is cut into three slots on the data line. The first slot carries TMS, the second carries TDI, and in the third the master releases the line so the target can return TDO. A bit-rate enable input, `tick`, sets the pace. Every step of the slot schedule lasts one tick.

Software or a higher-level engine issues a command. The command gives a mode, one fixed bit and a cycle count written as cycles minus one. In the TDI-stream mode, TMS is held at the fixed bit and TDI bits are taken from a byte stream. The TDO bits are collected into output bytes. In the TMS-stream mode, TMS bits come from the stream, TDI is held at the fixed bit and TDO is discarded. Between commands, and whenever the input stream runs dry, the link clock rests high so the target stays in debug mode.

The caller must keep the tick rate high enough that no low phase of the link clock (two ticks) exceeds 7 µs.

Top module: `tw_jtag_link`

## Requirements
- R1: After reset and between commands, `link_clk` is 1, `dio_oe` is 0, `dio_out` is 0, `busy` is 0 and `in_ready` is 0.
- R2: While busy, each JTAG cycle runs through steps 0 to 12. A step advances only on a clock where `tick` is 1. `link_clk` is high in steps 0, 1, 4, 5, 8, 9 and 12, and low in steps 2, 3, 6, 7, 10 and 11.
- R3: `dio_oe` is 1 in steps 0 to 7 and 0 in steps 8 to 12. TDO is sampled from `dio_in` on the tick that ends step 11, while the clock is low.
- R4: With `cmd_mode`=0, `dio_out` carries the fixed bit in steps 0 to 3 and the current stream bit in steps 4 to 7. The value is constant while `link_clk` is low and `dio_oe` is 1.
- R5: With `cmd_mode`=1, `dio_out` carries the current stream bit in steps 0 to 3 and the fixed bit in steps 4 to 7. No output byte is produced.
- R6: Each JTAG cycle uses one stream bit, taken MSB first (bit 7 first). Each command starts with a fresh byte, and unused bits of its last byte are dropped, so a command of N cycles takes ceil(N/8) bytes.
- R7: In mode 0, every eighth captured TDO bit completes a byte. That byte appears on `out_data` with `out_valid` high for one clock, and the first captured bit is in bit 7.
- R8: In mode 0, if k (1 to 7) bits remain uncaptured into a byte when the command ends, they are flushed in bits k-1..0 with the earliest bit highest and the upper bits 0. The flush happens on the clock where `busy` falls.
- R9: A command with `cmd_count`=C runs exactly C+1 JTAG cycles, which is 3(C+1) falling edges of `link_clk`.
- R10: `cmd_valid` is accepted only when `busy` is 0, and `busy` rises on the next clock. `busy` stays 1 until the tick that ends step 12 of the final cycle. `cmd_valid` while busy has no effect.
- R11: `in_ready` is 1 only while busy, in step 0, with no stream bit left. In that state the step does not advance and `link_clk` stays high until a byte is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Bit-rate enable; one step per tick |
| cmd_valid | input | 1 | Command strobe |
| cmd_mode | input | 1 | 0: TDI streamed, TDO captured; 1: TMS streamed |
| cmd_fixed | input | 1 | Fixed TMS (mode 0) or fixed TDI (mode 1) |
| cmd_count | input | CNT_W | Number of JTAG cycles minus one |
| busy | output | 1 | Command in progress |
| in_data | input | BYTE_W | Stream byte, MSB sent first |
| in_valid | input | 1 | Stream byte available |
| in_ready | output | 1 | Sequencer takes the byte this clock |
| out_data | output | BYTE_W | Captured TDO byte |
| out_valid | output | 1 | One-clock strobe for out_data |
| link_clk | output | 1 | Link clock to the target |
| dio_out | output | 1 | Data line value when driven |
| dio_oe | output | 1 | Data line drive enable |
| dio_in | input | 1 | Data line value seen from the pad |

## Verification
The embedded assertions check on every cycle that the clock rests high when idle or stalled, that the line is released only while the clock is high, and that driven data stays still through each low phase. They also check that the input stream is never shifted past its last bit, that output strobes never come back to back, and that a command arriving mid-run changes nothing. Bit order, the right-aligned partial flush, the exact cycle count, the bytes used per command and the step-by-step waveform under slow and stalled ticks only show up when the bench compares against its reference model over full commands.

// File: rtl/tw_jtag_pkg.sv
// Package: shared constants and types for the two-wire JTAG sequencer.
// Assumes a 13-step JTAG cycle: TMS slot (0-3), TDI slot (4-7), TDO slot (8-12).
package tw_jtag_pkg;

    localparam int STEPS  = 13;
    localparam int STEP_W = $clog2(STEPS);

    localparam logic [STEP_W-1:0] ST_FIRST   = STEP_W'(0);
    localparam logic [STEP_W-1:0] ST_TDI_LO  = STEP_W'(4);
    localparam logic [STEP_W-1:0] ST_TDO_LO  = STEP_W'(8);
    localparam logic [STEP_W-1:0] ST_SAMPLE  = STEP_W'(11);
    localparam logic [STEP_W-1:0] ST_LAST    = STEP_W'(STEPS - 1);

    typedef enum logic {
        MODE_TDI_STREAM = 1'b0,
        MODE_TMS_STREAM = 1'b1
    } tw_mode_e;

    // Link clock level for a step: two high, two low per slot, trailing high step.
    function automatic logic step_clk_level(input logic [STEP_W-1:0] s);
        logic lvl;
        if (s == ST_LAST) lvl = 1'b1;
        else              lvl = (s[1:0] < 2'd2);
        return lvl;
    endfunction

endpackage

// File: rtl/tw_slot_timer.sv
// Module: step counter for one JTAG cycle and decode of clock level,
// drive window and slot selection. Assumes run is low between commands,
// which parks the counter at step 0. hold stalls only step 0.
module tw_slot_timer
    import tw_jtag_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              tick,
    input  logic              hold,
    output logic [STEP_W-1:0] step_o,
    output logic              wrap_o,
    output logic              sample_o,
    output logic              clk_lvl_o,
    output logic              drive_o,
    output logic              tdi_slot_o
);

    logic [STEP_W-1:0] step_q;
    logic              advance;

    // Step may move on a tick unless step 0 is waiting for stream data.
    always_comb begin
        advance = run && tick && !(hold && (step_q == ST_FIRST));
    end

    // Step counter: wraps after the last step, resets while idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)      step_q <= ST_FIRST;
        else if (advance)        step_q <= (step_q == ST_LAST) ? ST_FIRST : step_q + 1'b1;
    end

    // Decode of slot position into link controls.
    always_comb begin
        step_o     = step_q;
        wrap_o     = advance && (step_q == ST_LAST);
        sample_o   = advance && (step_q == ST_SAMPLE);
        clk_lvl_o  = step_clk_level(step_q);
        drive_o    = (step_q < ST_TDO_LO);
        tdi_slot_o = (step_q >= ST_TDI_LO) && (step_q < ST_TDO_LO);
    end

endmodule

// File: rtl/tw_tx_unpack.sv
// Module: splits stream bytes into bits, MSB first. Assumes consume is raised
// only when a bit is present; clear discards any leftover bits.
module tw_tx_unpack #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              want,
    input  logic              consume,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    output logic              empty_o,
    output logic              bit_o
);

    localparam int CNT_W = $clog2(BYTE_W + 1);

    logic [BYTE_W-1:0] shreg_q;
    logic [CNT_W-1:0]  left_q;

    // Ready to take a byte only when asked and no bit remains.
    always_comb begin
        empty_o  = (left_q == '0);
        in_ready = want && empty_o;
        bit_o    = shreg_q[BYTE_W-1];
    end

    // Byte load and per-cycle shift toward the MSB.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            left_q  <= '0;
            shreg_q <= '0;
        end else if (in_valid && in_ready) begin
            shreg_q <= in_data;
            left_q  <= CNT_W'(BYTE_W);
        end else if (consume) begin
            shreg_q <= {shreg_q[BYTE_W-2:0], 1'b0};
            left_q  <= left_q - 1'b1;
        end
    end

    // R6
    no_underrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
        consume |-> (left_q != '0));

endmodule

// File: rtl/tw_rx_pack.sv
// Module: gathers TDO bits into bytes, first bit in the MSB; flush emits a
// partial byte right-aligned. Assumes capture and flush never coincide.
module tw_rx_pack #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              capture,
    input  logic              bit_in,
    input  logic              flush,
    output logic [BYTE_W-1:0] out_data,
    output logic              out_valid
);

    localparam int CNT_W = $clog2(BYTE_W);

    logic [BYTE_W-1:0] acc_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [BYTE_W-1:0] acc_next;

    // Accumulator with the new bit appended at the LSB.
    always_comb begin
        acc_next = {acc_q[BYTE_W-2:0], bit_in};
    end

    // Collect bits, emit full bytes and flush a partial one on request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q     <= '0;
            cnt_q     <= '0;
            out_data  <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            if (clear) begin
                acc_q <= '0;
                cnt_q <= '0;
            end else if (capture) begin
                if (cnt_q == CNT_W'(BYTE_W - 1)) begin
                    out_data  <= acc_next;
                    out_valid <= 1'b1;
                    acc_q     <= '0;
                    cnt_q     <= '0;
                end else begin
                    acc_q <= acc_next;
                    cnt_q <= cnt_q + 1'b1;
                end
            end else if (flush && (cnt_q != '0)) begin
                out_data  <= acc_q;
                out_valid <= 1'b1;
                acc_q     <= '0;
                cnt_q     <= '0;
            end
        end
    end

    // R7
    strobe_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

endmodule

// File: rtl/tw_jtag_link.sv
// Module: top of the two-wire JTAG master. Accepts a command, runs the
// requested number of three-slot JTAG cycles and streams bits in and out.
// Assumes tick is fast enough that two ticks stay under the low-phase limit,
// and that the pad combines dio_out/dio_oe/dio_in outside this block.
module tw_jtag_link
    import tw_jtag_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              cmd_valid,
    input  logic              cmd_mode,
    input  logic              cmd_fixed,
    input  logic [CNT_W-1:0]  cmd_count,
    output logic              busy,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    output logic [BYTE_W-1:0] out_data,
    output logic              out_valid,
    output logic              link_clk,
    output logic              dio_out,
    output logic              dio_oe,
    input  logic              dio_in
);

    logic              busy_q;
    tw_mode_e          mode_q;
    logic              fixed_q;
    logic [CNT_W-1:0]  left_q;

    logic              accept;
    logic              last_wrap;
    logic [STEP_W-1:0] step;
    logic              wrap;
    logic              sample;
    logic              clk_lvl;
    logic              drive;
    logic              tdi_slot;
    logic              tx_empty;
    logic              tx_bit;
    logic              tms_val;
    logic              tdi_val;

    // Command accept and end-of-command detection.
    always_comb begin
        accept    = cmd_valid && !busy_q;
        last_wrap = busy_q && wrap && (left_q == '0);
    end

    // Command registers and cycle down-counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            mode_q  <= MODE_TDI_STREAM;
            fixed_q <= 1'b0;
            left_q  <= '0;
        end else if (accept) begin
            busy_q  <= 1'b1;
            mode_q  <= tw_mode_e'(cmd_mode);
            fixed_q <= cmd_fixed;
            left_q  <= cmd_count;
        end else if (busy_q && wrap) begin
            if (left_q == '0) busy_q <= 1'b0;
            else              left_q <= left_q - 1'b1;
        end
    end

    tw_slot_timer u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (busy_q),
        .tick       (tick),
        .hold       (tx_empty),
        .step_o     (step),
        .wrap_o     (wrap),
        .sample_o   (sample),
        .clk_lvl_o  (clk_lvl),
        .drive_o    (drive),
        .tdi_slot_o (tdi_slot)
    );

    tw_tx_unpack #(.BYTE_W(BYTE_W)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (accept),
        .want     (busy_q && (step == ST_FIRST)),
        .consume  (wrap),
        .in_data  (in_data),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .empty_o  (tx_empty),
        .bit_o    (tx_bit)
    );

    tw_rx_pack #(.BYTE_W(BYTE_W)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (accept),
        .capture   (sample && (mode_q == MODE_TDI_STREAM)),
        .bit_in    (dio_in),
        .flush     (last_wrap && (mode_q == MODE_TDI_STREAM)),
        .out_data  (out_data),
        .out_valid (out_valid)
    );

    // Slot values: the streamed bit goes to whichever slot the mode selects.
    always_comb begin
        tms_val = (mode_q == MODE_TMS_STREAM) ? tx_bit : fixed_q;
        tdi_val = (mode_q == MODE_TMS_STREAM) ? fixed_q : tx_bit;
    end

    // Pin outputs: clock parks high and the line is released when idle.
    always_comb begin
        busy     = busy_q;
        link_clk = busy_q ? clk_lvl : 1'b1;
        dio_oe   = busy_q && drive;
        dio_out  = dio_oe ? (tdi_slot ? tdi_val : tms_val) : 1'b0;
    end

    // R1
    idle_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (link_clk && !dio_oe && !in_ready));

    // R3
    release_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dio_oe) |-> link_clk);

    // R4
    low_phase_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && dio_oe && !link_clk) |-> $stable(dio_out));

    // R11
    stall_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> link_clk);

    // R10
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_valid && !last_wrap) |=> (busy && $stable(mode_q) && $stable(fixed_q)));

endmodule

// File: tb/tw_jtag_link_bench.sv
// Bench: behavioural reference model compared with the design on every clock.
module tw_jtag_link_bench;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 16;
    localparam int BYTE_W     = 8;
    localparam int WATCHDOG   = 150000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tick = 1'b0;
    logic              cmd_valid = 1'b0;
    logic              cmd_mode = 1'b0;
    logic              cmd_fixed = 1'b0;
    logic [CNT_W-1:0]  cmd_count = '0;
    logic              busy;
    logic [BYTE_W-1:0] in_data = '0;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [BYTE_W-1:0] out_data;
    logic              out_valid;
    logic              link_clk;
    logic              dio_out;
    logic              dio_oe;
    logic              dio_in = 1'b0;

    tw_jtag_link #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_tw_jtag_link (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cmd_valid(cmd_valid),
        .cmd_mode(cmd_mode), .cmd_fixed(cmd_fixed), .cmd_count(cmd_count),
        .busy(busy), .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
        .out_data(out_data), .out_valid(out_valid), .link_clk(link_clk),
        .dio_out(dio_out), .dio_oe(dio_oe), .dio_in(dio_in)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int vectors = 0;
    int errors  = 0;
    int cycles  = 0;

    // Reference model state
    bit         m_busy = 0;
    int         m_ph = 0;
    int         m_left = 0;
    bit         m_mode = 0;
    bit         m_fix = 0;
    bit         bq[$];
    bit         cq[$];
    bit         m_ov = 0;
    bit         m_flush = 0;
    logic [7:0] m_od = '0;
    int         m_bytes_in = 0;
    logic [7:0] src[$];

    // Bench stimulus state
    int  tick_div = 1;
    int  tick_cnt = 0;
    int  stall_clks = 0;
    bit  allow = 1;
    logic [15:0] lfsr = 16'hACE1;
    int  falls = 0;
    logic prev_lclk = 1'b1;

    function automatic logic [7:0] pack_bits(input bit q[$]);
        logic [7:0] v = '0;
        foreach (q[i]) v = {v[6:0], q[i]};
        return v;
    endfunction

    function automatic bit m_clk();
        if (!m_busy) return 1;
        if (m_ph == 12) return 1;
        return (m_ph % 4) < 2;
    endfunction

    function automatic bit m_oe();
        return m_busy && (m_ph < 8);
    endfunction

    function automatic bit m_dout();
        bit sb;
        sb = (bq.size() > 0) ? bq[0] : 1'b0;
        if (!m_oe()) return 0;
        if (m_ph < 4) return m_mode ? sb : m_fix;
        return m_mode ? m_fix : sb;
    endfunction

    function automatic bit m_rdy();
        return m_busy && (m_ph == 0) && (bq.size() == 0);
    endfunction

    // Reference model advanced at each rising edge from the driven inputs.
    always @(posedge clk) begin
        m_ov = 0;
        m_flush = 0;
        if (!rst_n) begin
            m_busy = 0; m_ph = 0; bq.delete(); cq.delete();
        end else if (!m_busy) begin
            if (cmd_valid) begin
                m_busy = 1; m_ph = 0; m_left = int'(cmd_count);
                m_mode = cmd_mode; m_fix = cmd_fixed;
                bq.delete(); cq.delete();
            end
        end else if (m_ph == 0 && bq.size() == 0) begin
            if (in_valid) begin
                for (int i = 7; i >= 0; i--) bq.push_back(in_data[i]);
                void'(src.pop_front());
                m_bytes_in++;
            end
        end else if (tick) begin
            if (m_ph == 11 && !m_mode) begin
                cq.push_back(dio_in);
                if (cq.size() == 8) begin
                    m_od = pack_bits(cq); m_ov = 1; cq.delete();
                end
            end
            if (m_ph == 12) begin
                void'(bq.pop_front());
                m_ph = 0;
                if (m_left == 0) begin
                    m_busy = 0;
                    if (cq.size() > 0) begin
                        m_od = pack_bits(cq); m_ov = 1; m_flush = 1; cq.delete();
                    end
                end else m_left--;
            end else m_ph++;
        end
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    endtask

    // Per-clock comparison against the model, then drive new inputs.
    task automatic step_clk();
        @(negedge clk);
        cycles++;
        if (cycles > WATCHDOG) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected <= %0d cycles", cycles, WATCHDOG);
            finish_run();
        end
        if (rst_n) begin
            chk(m_busy ? "R2 link_clk" : "R1 link_clk", 8'(link_clk), 8'(m_clk()));
            chk("R3 dio_oe", 8'(dio_oe), 8'(m_oe()));
            chk(m_mode ? "R5 dio_out" : "R4 dio_out", 8'(dio_out), 8'(m_dout()));
            chk("R10 busy", 8'(busy), 8'(m_busy));
            chk("R11 in_ready", 8'(in_ready), 8'(m_rdy()));
            chk(m_flush ? "R8 out_valid" : "R7 out_valid", 8'(out_valid), 8'(m_ov));
            if (m_ov) chk(m_flush ? "R8 out_data" : "R7 out_data", out_data, m_od);
            if (prev_lclk && !link_clk) falls++;
            prev_lclk = link_clk;
        end
        tick_cnt++;
        tick = (tick_cnt % tick_div) == 0;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        dio_in = lfsr[0];
        if (stall_clks > 0) stall_clks--;
        allow = (stall_clks == 0);
        in_valid = allow && (src.size() > 0);
        in_data  = (src.size() > 0) ? src[0] : 8'h00;
    endtask

    task automatic run_cmd(input bit mode, input bit fix, input int cnt,
                           input int div, input int stall, input bit poke);
        int nbytes;
        int b0;
        nbytes = (cnt + 8) / 8;
        src.delete();
        for (int i = 0; i < nbytes + 1; i++) src.push_back(8'($urandom_range(0, 255)));
        tick_div = div;
        stall_clks = stall;
        b0 = m_bytes_in;
        falls = 0;
        cmd_valid = 1'b1; cmd_mode = mode; cmd_fixed = fix; cmd_count = CNT_W'(cnt);
        step_clk();
        cmd_valid = 1'b0;
        if (poke) begin
            // R10: a second command mid-run must change nothing
            for (int i = 0; i < 40; i++) step_clk();
            cmd_valid = 1'b1; cmd_mode = ~mode; cmd_fixed = ~fix; cmd_count = CNT_W'(3);
            for (int i = 0; i < 5; i++) step_clk();
            cmd_valid = 1'b0;
        end
        while (m_busy) step_clk();
        for (int i = 0; i < 4; i++) step_clk();
        chk("R9 falling edges", 8'(falls), 8'(3 * (cnt + 1)));
        chk("R6 bytes used", 8'(m_bytes_in - b0), 8'(nbytes));
        chk("R1 idle park", 8'({link_clk, dio_oe, busy}), 8'(3'b100));
    endtask

    initial begin
        rst_n = 1'b0;
        for (int i = 0; i < 4; i++) step_clk();
        rst_n = 1'b1;
        step_clk();
        chk("R1 reset state", 8'({link_clk, dio_oe, dio_out, busy, in_ready, out_valid}),
            8'(6'b100000));
        run_cmd(1'b0, 1'b1, 15, 1, 0, 1'b0);   // R7 two full bytes
        run_cmd(1'b0, 1'b0, 10, 3, 0, 1'b0);   // R8 partial flush of 3 bits
        run_cmd(1'b1, 1'b1, 4, 2, 0, 1'b0);    // R5 TMS streamed
        run_cmd(1'b0, 1'b1, 0, 1, 0, 1'b0);    // R9 single cycle
        run_cmd(1'b0, 1'b0, 20, 1, 30, 1'b0);  // R11 stall at start
        run_cmd(1'b1, 1'b0, 12, 4, 0, 1'b1);   // R10 ignored command
        run_cmd(1'b0, 1'b1, 6, 2, 0, 1'b1);    // R8 seven-bit flush, R10
        finish_run();
    end

endmodule